// File: doc/BRIEF.md
# PCIe Root Port Power-Up Sequencer

This block walks a PCIe root port from cold reset to a trained link. After a start pulse it holds the endpoint in reset. It then switches on three supplies in turn. It turns on three clocks while the bus-interface logic is held in reset, and releases that reset. Next it takes the PHY out of power-down, sets the transmit termination offset and enables the reference clock. It then releases the four internal resets, lets the endpoint out of reset and enables link training. Finally it polls the link-up status bit at a fixed interval, and stops after a bounded number of samples with a pass flag or a timeout flag.

Every wait is a parameter counted in clock cycles, so one netlist serves any clock rate. The PHY, reference-clock and system-control words are full 32-bit registers because a neighbouring register block decodes their fields. The sequencer never hangs: it always reaches its final state, and a new start pulse from the idle or final state runs the whole sequence again.

Top module: `pcie_pwrup_seq`

## Requirements
- R1: Out of reset: ep_rst_n=0, vreg_en=0, bif_rst=0, clk_en=0, phy_ctrl=32'h0000_0001, refclk_ctrl=32'h0000_1000, blk_rst=4'hF, sys_ctrl=0, and done, link_ok and link_timeout are all 0.
- R2: On the edge that accepts start, every control output returns to its R1 value, so ep_rst_n is 0. Nothing else changes for EP_HOLD_CYC cycles.
- R3: The supply enables turn on one per STEP_CYC cycles in the order vreg_en bit 0 (core), bit 1 (reference-clock supply), bit 2 (analog).
- R4: bif_rst is then set, and clk_en bits 0 (interface), 1 (PHY) and 2 (core) turn on in that order, STEP_CYC apart. bif_rst is then cleared, and the next write to phy_ctrl comes BIF_WAIT_CYC cycles later.
- R5: phy_ctrl bit 0 (power-down) is cleared first. STEP_CYC later, bits 20:16 (termination offset) become 7, so the word reads 32'h0007_0000.
- R6: STEP_CYC later, refclk_ctrl bit 16 is set. Bit 12 is cleared when ext_refclk is 0 and kept at its reset value of 1 when ext_refclk is 1. ext_refclk is sampled on that same edge.
- R7: blk_rst bits 0 (PHY), 1 (core), 2 (power-on) and 3 (AXI) are released in that order. After the last release the sequencer waits SETTLE_CYC cycles, and then ep_rst_n goes high.
- R8: EP_REL_CYC cycles after ep_rst_n rises, sys_ctrl bit 0 (training enable) is set. link_status bit 29 is then sampled every POLL_CYC cycles, and no other bit of link_status has any effect.
- R9: On the first sample that sees bit 29 high, done and link_ok go high on that edge.
- R10: If POLL_MAX samples all see bit 29 low, done and link_timeout go high after POLL_MAX*POLL_CYC cycles of polling. link_ok and link_timeout are never both high.
- R11: start is ignored while a sequence is running. From the idle or final state it restarts the sequence and clears done, link_ok and link_timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted in idle or final state |
| ext_refclk | input | 1 | Strap: reference clock comes from outside |
| link_status | input | 32 | Link status word; bit 29 means link up |
| ep_rst_n | output | 1 | Endpoint reset pin, low holds the endpoint in reset |
| vreg_en | output | 3 | Supply enables: core, reference-clock, analog |
| bif_rst | output | 1 | Bus-interface logic reset |
| clk_en | output | 3 | Clock enables: interface, PHY, core |
| phy_ctrl | output | 32 | PHY control word |
| refclk_ctrl | output | 32 | Reference-clock control word |
| blk_rst | output | 4 | PHY, core, power-on and AXI resets, active high |
| sys_ctrl | output | 32 | System control word; bit 0 enables link training |
| done | output | 1 | Sequence finished |
| link_ok | output | 1 | Finished with link up |
| link_timeout | output | 1 | Finished without link up |

## Verification
The bench runs the sequence three times and checks every output against a timeline model on every cycle. The first run has the strap low and the link coming up on the second sample, and link_status carries every bit except 29. This shows that only bit 29 is decoded and that the pass path stops early. The second run has the strap high and no link. It separates the two refclk_ctrl endings and shows that the timeout comes after exactly POLL_MAX intervals. The third run restarts from the final state with the link already up, which shows that the restart reloads the defaults and that a pass on the first sample works. A start pulse is also sent in the middle of a run, where any reaction to it would break the per-cycle match.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_EP_HOLD,
        S_VREG0, S_VREG1, S_VREG2,
        S_BIF_ON,
        S_CLK0, S_CLK1, S_CLK2,
        S_BIF_OFF,
        S_PHY_PWR, S_PHY_TERM, S_REFCLK,
        S_RST0, S_RST1, S_RST2, S_RST3,
        S_EP_REL, S_POLL, S_DONE
    } pwr_state_t;

    localparam int N_VREG = 3;
    localparam int N_CLK  = 3;
    localparam int N_BLK  = 4;

    localparam int PHY_PD_BIT   = 0;
    localparam int TERM_LSB     = 16;
    localparam int TERM_W       = 5;
    localparam logic [TERM_W-1:0] TERM_VAL = 5'd7;
    localparam int REF_EN_BIT   = 16;
    localparam int REF_INT_BIT  = 12;
    localparam int TRAIN_BIT    = 0;
    localparam int LINK_UP_BIT  = 29;

    localparam logic [31:0] PHY_DEF = 32'h0000_0001;
    localparam logic [31:0] REF_DEF = 32'h0000_1000;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
    import pwrup_pkg::*;
#(
    parameter int EP_HOLD_CYC  = 1250000,
    parameter int STEP_CYC     = 1,
    parameter int BIF_WAIT_CYC = 125,
    parameter int SETTLE_CYC   = 1250000,
    parameter int EP_REL_CYC   = 1250000,
    parameter int POLL_CYC     = 1250000,
    parameter int POLL_MAX     = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        link_up,
    output pwr_state_t  state_q,
    output pwr_state_t  state_d,
    output logic        load_def,
    output logic        enter,
    output logic        link_ok,
    output logic        link_timeout
);
    localparam int MAXD  = max_i(max_i(max_i(EP_HOLD_CYC, STEP_CYC), max_i(BIF_WAIT_CYC, SETTLE_CYC)),
                                 max_i(EP_REL_CYC, POLL_CYC));
    localparam int CNT_W = cnt_width(MAXD);
    localparam int PW    = cnt_width(POLL_MAX + 1);

    localparam logic [CNT_W-1:0] L_EP   = CNT_W'(EP_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] L_STEP = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] L_BIF  = CNT_W'(BIF_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] L_SET  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] L_REL  = CNT_W'(EP_REL_CYC - 1);
    localparam logic [CNT_W-1:0] L_POLL = CNT_W'(POLL_CYC - 1);
    localparam logic [PW-1:0]    P_LAST = PW'(POLL_MAX - 1);

    logic [CNT_W-1:0] limit;
    logic             last, parked;
    logic [PW-1:0]    poll_q, poll_d;
    logic             ok_d, to_d;

    assign parked = (state_q == S_IDLE) || (state_q == S_DONE);

    always_comb begin
        case (state_q)
            S_EP_HOLD: limit = L_EP;
            S_BIF_OFF: limit = L_BIF;
            S_RST3:    limit = L_SET;
            S_EP_REL:  limit = L_REL;
            S_POLL:    limit = L_POLL;
            default:   limit = L_STEP;
        endcase
    end

    pwrup_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (last || parked),
        .limit (limit),
        .last  (last)
    );

    always_comb begin
        state_d = state_q;
        poll_d  = poll_q;
        ok_d    = link_ok;
        to_d    = link_timeout;
        case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_d = S_EP_HOLD;
                    poll_d  = '0;
                    ok_d    = 1'b0;
                    to_d    = 1'b0;
                end
            end
            S_POLL: begin
                if (last) begin
                    if (link_up) begin
                        state_d = S_DONE;
                        ok_d    = 1'b1;
                    end else if (poll_q == P_LAST) begin
                        state_d = S_DONE;
                        to_d    = 1'b1;
                    end else begin
                        poll_d = poll_q + 1'b1;
                    end
                end
            end
            default: if (last) state_d = pwr_state_t'(state_q + 5'd1);
        endcase
    end

    assign load_def = parked && start;
    assign enter    = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            poll_q       <= '0;
            link_ok      <= 1'b0;
            link_timeout <= 1'b0;
        end else begin
            state_q      <= state_d;
            poll_q       <= poll_d;
            link_ok      <= ok_d;
            link_timeout <= to_d;
        end
    end
endmodule

// File: rtl/pwrup_ctrl_regs.sv
module pwrup_ctrl_regs
    import pwrup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_def,
    input  logic              enter,
    input  pwr_state_t        tgt,
    input  logic              ext_refclk,
    output logic              ep_rst_n,
    output logic [N_VREG-1:0] vreg_en,
    output logic              bif_rst,
    output logic [N_CLK-1:0]  clk_en,
    output logic [31:0]       phy_ctrl,
    output logic [31:0]       refclk_ctrl,
    output logic [N_BLK-1:0]  blk_rst,
    output logic [31:0]       sys_ctrl
);
    logic clr;
    assign clr = rst || load_def;

    for (genvar i = 0; i < N_VREG; i++) begin : g_vreg
        always_ff @(posedge clk) begin
            if (clr) vreg_en[i] <= 1'b0;
            else if (enter && tgt == pwr_state_t'(5'(S_VREG0) + 5'(i))) vreg_en[i] <= 1'b1;
        end
    end

    for (genvar i = 0; i < N_CLK; i++) begin : g_clk
        always_ff @(posedge clk) begin
            if (clr) clk_en[i] <= 1'b0;
            else if (enter && tgt == pwr_state_t'(5'(S_CLK0) + 5'(i))) clk_en[i] <= 1'b1;
        end
    end

    for (genvar i = 0; i < N_BLK; i++) begin : g_blk
        always_ff @(posedge clk) begin
            if (clr) blk_rst[i] <= 1'b1;
            else if (enter && tgt == pwr_state_t'(5'(S_RST0) + 5'(i))) blk_rst[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ep_rst_n    <= 1'b0;
            bif_rst     <= 1'b0;
            phy_ctrl    <= PHY_DEF;
            refclk_ctrl <= REF_DEF;
            sys_ctrl    <= '0;
        end else if (enter) begin
            case (tgt)
                S_BIF_ON:   bif_rst <= 1'b1;
                S_BIF_OFF:  bif_rst <= 1'b0;
                S_PHY_PWR:  phy_ctrl[PHY_PD_BIT] <= 1'b0;
                S_PHY_TERM: phy_ctrl[TERM_LSB +: TERM_W] <= TERM_VAL;
                S_REFCLK: begin
                    refclk_ctrl[REF_EN_BIT] <= 1'b1;
                    if (!ext_refclk) refclk_ctrl[REF_INT_BIT] <= 1'b0;
                end
                S_EP_REL:   ep_rst_n <= 1'b1;
                S_POLL:     sys_ctrl[TRAIN_BIT] <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcie_pwrup_seq.sv
module pcie_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int EP_HOLD_CYC  = 1250000,
    parameter int STEP_CYC     = 1,
    parameter int BIF_WAIT_CYC = 125,
    parameter int SETTLE_CYC   = 1250000,
    parameter int EP_REL_CYC   = 1250000,
    parameter int POLL_CYC     = 1250000,
    parameter int POLL_MAX     = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ext_refclk,
    input  logic [31:0] link_status,
    output logic        ep_rst_n,
    output logic [2:0]  vreg_en,
    output logic        bif_rst,
    output logic [2:0]  clk_en,
    output logic [31:0] phy_ctrl,
    output logic [31:0] refclk_ctrl,
    output logic [3:0]  blk_rst,
    output logic [31:0] sys_ctrl,
    output logic        done,
    output logic        link_ok,
    output logic        link_timeout
);
    pwr_state_t state_q, state_d;
    logic       load_def, enter;

    pwrup_fsm #(
        .EP_HOLD_CYC (EP_HOLD_CYC),
        .STEP_CYC    (STEP_CYC),
        .BIF_WAIT_CYC(BIF_WAIT_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .EP_REL_CYC  (EP_REL_CYC),
        .POLL_CYC    (POLL_CYC),
        .POLL_MAX    (POLL_MAX)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .link_up     (link_status[LINK_UP_BIT]),
        .state_q     (state_q),
        .state_d     (state_d),
        .load_def    (load_def),
        .enter       (enter),
        .link_ok     (link_ok),
        .link_timeout(link_timeout)
    );

    pwrup_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .load_def   (load_def),
        .enter      (enter),
        .tgt        (state_d),
        .ext_refclk (ext_refclk),
        .ep_rst_n   (ep_rst_n),
        .vreg_en    (vreg_en),
        .bif_rst    (bif_rst),
        .clk_en     (clk_en),
        .phy_ctrl   (phy_ctrl),
        .refclk_ctrl(refclk_ctrl),
        .blk_rst    (blk_rst),
        .sys_ctrl   (sys_ctrl)
    );

    assign done = (state_q == S_DONE);
endmodule

// File: rtl/pwrup_chk.sv
module pwrup_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        ep_rst_n,
    input logic [2:0]  vreg_en,
    input logic        bif_rst,
    input logic [2:0]  clk_en,
    input logic [31:0] phy_ctrl,
    input logic [3:0]  blk_rst,
    input logic [31:0] sys_ctrl,
    input logic        done,
    input logic        link_ok,
    input logic        link_timeout
);
    a_r2_ep_low_only_on_start: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_rst_n) |-> $past(start));

    a_r3_supply_order: assert property (@(posedge clk) disable iff (rst)
        (vreg_en[2] |-> vreg_en[1]) and (vreg_en[1] |-> vreg_en[0]));

    a_r4_clock_order: assert property (@(posedge clk) disable iff (rst)
        (clk_en[2] |-> clk_en[1]) and (clk_en[1] |-> clk_en[0]) and (clk_en[0] |-> vreg_en[2]));

    a_r5_phy_after_bif: assert property (@(posedge clk) disable iff (rst)
        !phy_ctrl[0] |-> (!bif_rst && clk_en == 3'b111));

    a_r7_reset_order: assert property (@(posedge clk) disable iff (rst)
        (!blk_rst[3] |-> !blk_rst[2]) and (!blk_rst[2] |-> !blk_rst[1]) and (!blk_rst[1] |-> !blk_rst[0]));

    a_r7_ep_after_resets: assert property (@(posedge clk) disable iff (rst)
        ep_rst_n |-> (blk_rst == 4'h0 && !phy_ctrl[0]));

    a_r8_train_after_ep: assert property (@(posedge clk) disable iff (rst)
        sys_ctrl[0] |-> ep_rst_n);

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(link_ok && link_timeout));

    a_r9_flags_need_done: assert property (@(posedge clk) disable iff (rst)
        (link_ok || link_timeout) |-> done);
endmodule

bind pcie_pwrup_seq pwrup_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ep_rst_n    (ep_rst_n),
    .vreg_en     (vreg_en),
    .bif_rst     (bif_rst),
    .clk_en      (clk_en),
    .phy_ctrl    (phy_ctrl),
    .blk_rst     (blk_rst),
    .sys_ctrl    (sys_ctrl),
    .done        (done),
    .link_ok     (link_ok),
    .link_timeout(link_timeout)
);

// File: tb/pcie_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module pcie_pwrup_seq_tb_top;
    localparam int EPH = 20, STP = 2, BIFW = 5, SET = 15, EPR = 12, POLL = 10, PMAX = 4;
    localparam int NSTEP = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ext_refclk = 1'b0;
    logic [31:0] link_status = 32'h0;
    logic        ep_rst_n, bif_rst, done, link_ok, link_timeout;
    logic [2:0]  vreg_en, clk_en;
    logic [3:0]  blk_rst;
    logic [31:0] phy_ctrl, refclk_ctrl, sys_ctrl;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pcie_pwrup_seq #(
        .EP_HOLD_CYC(EPH), .STEP_CYC(STP), .BIF_WAIT_CYC(BIFW), .SETTLE_CYC(SET),
        .EP_REL_CYC(EPR), .POLL_CYC(POLL), .POLL_MAX(PMAX)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .ext_refclk(ext_refclk),
        .link_status(link_status), .ep_rst_n(ep_rst_n), .vreg_en(vreg_en),
        .bif_rst(bif_rst), .clk_en(clk_en), .phy_ctrl(phy_ctrl),
        .refclk_ctrl(refclk_ctrl), .blk_rst(blk_rst), .sys_ctrl(sys_ctrl),
        .done(done), .link_ok(link_ok), .link_timeout(link_timeout)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Timeline model: dwell of each step, entry offsets from the accepting edge
    int dw[NSTEP];
    int b[NSTEP+1];
    int mt = -1;
    bit m_done = 0, m_ok = 0, m_to = 0, m_strap = 0;
    bit cmp_en = 0;

    initial begin
        for (int i = 0; i < NSTEP; i++) dw[i] = STP;
        dw[0] = EPH; dw[8] = BIFW; dw[15] = SET; dw[16] = EPR;
        b[0] = 0;
        for (int i = 0; i < NSTEP; i++) b[i+1] = b[i] + dw[i];
    end

    always @(posedge clk) begin
        if (rst) begin
            mt = -1; m_done = 0; m_ok = 0; m_to = 0;
        end else if ((mt < 0 || m_done) && start) begin
            mt = 0; m_done = 0; m_ok = 0; m_to = 0;
        end else if (mt >= 0 && !m_done) begin
            mt++;
            if (mt == b[11]) m_strap = ext_refclk;
            if (mt > b[NSTEP] && ((mt - b[NSTEP]) % POLL) == 0) begin
                if (link_status[29]) begin m_done = 1; m_ok = 1; end
                else if ((mt - b[NSTEP]) / POLL == PMAX) begin m_done = 1; m_to = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            logic        e_ep, e_bif;
            logic [2:0]  e_vreg, e_clk;
            logic [3:0]  e_blk;
            logic [31:0] e_phy, e_ref, e_sys;
            e_ep = 0; e_bif = 0; e_vreg = 0; e_clk = 0; e_blk = 4'hF;
            e_phy = 32'h1; e_ref = 32'h1000; e_sys = 0;
            if (mt >= 0) begin
                for (int i = 0; i < 3; i++) begin
                    e_vreg[i] = (mt >= b[1+i]);
                    e_clk[i]  = (mt >= b[5+i]);
                end
                for (int i = 0; i < 4; i++) e_blk[i] = !(mt >= b[12+i]);
                e_bif = (mt >= b[4]) && (mt < b[8]);
                if (mt >= b[9])  e_phy[0] = 1'b0;
                if (mt >= b[10]) e_phy[20:16] = 5'd7;
                if (mt >= b[11]) begin
                    e_ref[16] = 1'b1;
                    if (!m_strap) e_ref[12] = 1'b0;
                end
                e_ep = (mt >= b[16]);
                e_sys[0] = (mt >= b[NSTEP]);
            end
            check(ep_rst_n == e_ep, "R2/R7 ep_rst_n", 32'(ep_rst_n), 32'(e_ep));
            check(vreg_en == e_vreg, "R3 vreg_en", 32'(vreg_en), 32'(e_vreg));
            check(bif_rst == e_bif && clk_en == e_clk, "R4 bif_rst/clk_en",
                  {27'b0, bif_rst, 1'b0, clk_en}, {27'b0, e_bif, 1'b0, e_clk});
            check(phy_ctrl == e_phy, "R5 phy_ctrl", phy_ctrl, e_phy);
            check(refclk_ctrl == e_ref, "R6 refclk_ctrl", refclk_ctrl, e_ref);
            check(blk_rst == e_blk, "R7 blk_rst", 32'(blk_rst), 32'(e_blk));
            check(sys_ctrl == e_sys, "R8 sys_ctrl", sys_ctrl, e_sys);
            check({done, link_ok, link_timeout} == {m_done, m_ok, m_to}, "R9/R10/R11 status",
                  {29'b0, done, link_ok, link_timeout}, {29'b0, m_done, m_ok, m_to});
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 50000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check(ep_rst_n == 0 && vreg_en == 0 && bif_rst == 0 && clk_en == 0, "R1 pins", 32'({ep_rst_n, vreg_en, bif_rst, clk_en}), 32'h0);
        check(phy_ctrl == 32'h1 && refclk_ctrl == 32'h1000, "R1 phy/ref", phy_ctrl ^ refclk_ctrl, 32'h1001);
        check(blk_rst == 4'hF && sys_ctrl == 0 && !done && !link_ok && !link_timeout, "R1 resets/status",
              32'({blk_rst, done, link_ok, link_timeout}), 32'h78);
        cmp_en = 1;

        // Run A: internal clock, noise on all bits except 29, link up on the second sample
        ext_refclk = 1'b0;
        link_status = 32'hDFFF_FFFF;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();  // R11: ignored while running
        for (int i = 0; i < 500 && !sys_ctrl[0]; i++) @(negedge clk);
        repeat (15) @(negedge clk);
        link_status = 32'h2000_0000;
        wait_done();
        check(done && link_ok && !link_timeout, "R9 link pass", 32'({done, link_ok, link_timeout}), 32'h6);
        check(refclk_ctrl == 32'h0001_0000, "R6 internal refclk", refclk_ctrl, 32'h0001_0000);
        check(phy_ctrl == 32'h0007_0000, "R5 final phy_ctrl", phy_ctrl, 32'h0007_0000);

        // Run B: external clock strap, link never up
        ext_refclk = 1'b1;
        link_status = 32'hDFFF_FFFF;
        pulse_start();
        for (int i = 0; i < 500 && !sys_ctrl[0]; i++) @(negedge clk);
        begin
            int n = 0;
            while (!done && n < 500) begin @(negedge clk); n++; end
            check(n == POLL * PMAX, "R8/R10 polling window", 32'(n), 32'(POLL * PMAX));
        end
        check(done && link_timeout && !link_ok, "R10 timeout", 32'({done, link_ok, link_timeout}), 32'h5);
        check(refclk_ctrl == 32'h0001_1000, "R6 external refclk", refclk_ctrl, 32'h0001_1000);

        // Run C: restart from the final state with link already up
        link_status = 32'h2000_0000;
        pulse_start();
        check(!done && !link_ok && !link_timeout && !ep_rst_n && phy_ctrl == 32'h1, "R11 restart clears",
              32'({done, link_ok, link_timeout, ep_rst_n}), 32'h0);
        wait_done();
        check(done && link_ok, "R9 first-sample pass", 32'({done, link_ok}), 32'h3);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule